// File: doc/BRIEF.md
# Parallel-Access Shift Register with J-K First Stage

This block is a register of `WIDTH` flip-flops (eight by default) that, on each rising clock edge, either loads a whole word from a parallel input or shifts its contents one place toward the higher bit index. A mode select input chooses between the two operations. An active-low clock enable turns any edge into a hold when it is high.

During a shift, bit 0 does not take a plain serial bit. It is driven by a J input and an inverted-K input, so the first stage can be set, cleared, toggled or left as it is while the other bits move along. Tying the two inputs together gives an ordinary D-type serial input. The register contents appear directly on the output. An active-low asynchronous reset clears every bit at once.

Top module: `pashift_jk`

## Requirements
- R1: While `rst_n` is low, every bit of `q` is 0 immediately, without waiting for a clock edge, and the reset wins over every other input.
- R2: `q` changes only on a rising edge of `clk` (or through reset); input changes between edges leave it unchanged.
- R3: When `hold_n` is high at a rising edge, `q` keeps its value, whatever `shift_sel`, `j_in`, `kbar_in` and `d` are.
- R4: When `hold_n` is low and `shift_sel` is 0, a rising edge copies `d[i]` into `q[i]` for every i.
- R5: When `hold_n` is low and `shift_sel` is 1, a rising edge moves each `q[i]` into `q[i+1]`, and the old top bit `q[WIDTH-1]` is lost.
- R6: In shift mode, with `j_in`=1 and `kbar_in`=1, `q[0]` becomes 1.
- R7: In shift mode, with `j_in`=0 and `kbar_in`=0, `q[0]` becomes 0.
- R8: In shift mode, with `j_in`=1 and `kbar_in`=0, `q[0]` becomes the inverse of its previous value.
- R9: In shift mode, with `j_in`=0 and `kbar_in`=1, `q[0]` keeps its previous value.
- R10: With `j_in` and `kbar_in` driven by the same value, a shift loads that value into `q[0]`.
- R11: The first rising edge after `rst_n` goes high follows the normal mode selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers happen on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| hold_n | input | 1 | Clock enable, active low; high holds the register |
| shift_sel | input | 1 | 1 selects shift, 0 selects parallel load |
| j_in | input | 1 | J control of the first stage |
| kbar_in | input | 1 | Inverted-K control of the first stage |
| d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Register contents |

## Verification
The bench builds the block with the default `WIDTH` of 8. At this width, full-byte patterns such as 0xA5 and 0xFF push set bits through every stage, and they show a 1 falling off `q[7]` during a shift. The same patterns take the first stage through all four J / inverted-K combinations. Toggling twice in a row checks that the toggle uses the stage's previous value and not a constant.

// File: rtl/pashift_jk.sv
module pashift_jk #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_n,
  input  logic             shift_sel,
  input  logic             j_in,
  input  logic             kbar_in,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] state;
  logic             first_nxt;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] next_state;

  assign first_nxt  = (j_in & ~state[0]) | (kbar_in & state[0]);
  assign shifted    = {state[WIDTH-2:0], first_nxt};
  assign next_state = hold_n ? state : (shift_sel ? shifted : d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= next_state;
  end

  assign q = state;

endmodule

// File: rtl/pashift_jk_chk.sv
module pashift_jk_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_n,
  input logic             shift_sel,
  input logic             j_in,
  input logic             kbar_in,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q
);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (q == '0);
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_n |=> $stable(q));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !shift_sel) |=> (q == $past(d)));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && shift_sel) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && shift_sel && j_in && kbar_in) |=> q[0]);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && shift_sel && !j_in && !kbar_in) |=> !q[0]);

  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && shift_sel && j_in && !kbar_in) |=> (q[0] != $past(q[0])));

  assert_retain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && shift_sel && !j_in && kbar_in) |=> $stable(q[0]));

endmodule

bind pashift_jk pashift_jk_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .shift_sel(shift_sel),
  .j_in(j_in), .kbar_in(kbar_in), .d(d), .q(q)
);

// File: tb/tb_pashift_jk.sv
module tb_pashift_jk;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         hold_n = 1'b1;
  logic         shift_sel = 1'b0;
  logic         j_in = 1'b0;
  logic         kbar_in = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pashift_jk #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .shift_sel(shift_sel),
    .j_in(j_in), .kbar_in(kbar_in), .d(d), .q(q)
  );

  always #5 clk = ~clk;

  // vector: {req[3:0], hold_n, shift_sel, j_in, kbar_in, d[7:0], expected q[7:0]}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R4 load
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5},  // R3 hold over load
    {4'd3,  1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hA5},  // R3 hold over shift
    {4'd6,  1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h4B},  // R6 set, R5 move
    {4'd7,  1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96},  // R7 clear
    {4'd8,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h2D},  // R8 toggle 0->1
    {4'd8,  1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h5A},  // R8 toggle 1->0
    {4'd9,  1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hB4},  // R9 retain 0
    {4'd4,  1'b0, 1'b0, 1'b1, 1'b0, 8'h81, 8'h81},  // R4 load
    {4'd9,  1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h03},  // R9 retain 1
    {4'd10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h07},  // R10 D=1
    {4'd10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0E},  // R10 D=0
    {4'd4,  1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF},  // R4 load
    {4'd5,  1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFE}   // R5 top bit lost
  };

  task automatic check(input string req, input logic [W-1:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%h expected=%h", req, q, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    hold_n = 1'b0;
    d = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset holds zero over load", '0);
    rst_n = 1'b1;
    hold_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      hold_n    = VEC[i][19];
      shift_sel = VEC[i][18];
      j_in      = VEC[i][17];
      kbar_in   = VEC[i][16];
      d         = VEC[i][15:8];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][23:20], i), VEC[i][7:0]);
    end

    // R2: input changes between edges do not reach q
    hold_n = 1'b0; shift_sel = 1'b0; d = 8'h3C;
    @(negedge clk);
    check("R2 load before change", 8'h3C);
    d = 8'hC3;
    #2;
    check("R2 mid-cycle change ignored", 8'h3C);
    shift_sel = 1'b1; j_in = 1'b1; kbar_in = 1'b1;
    #1;
    check("R2 mode change ignored", 8'h3C);
    shift_sel = 1'b0;
    @(negedge clk);
    check("R2 takes effect at edge", 8'hC3);

    // R1: asynchronous clear mid-cycle
    d = 8'h77;
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", '0);
    @(negedge clk);
    check("R1 clear beats load", '0);

    // R11: first edge after release follows mode
    d = 8'h5A;
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first edge loads", 8'h5A);
    shift_sel = 1'b1; j_in = 1'b1; kbar_in = 1'b0;
    @(negedge clk);
    check("R11 then shift toggle (R8)", 8'hB5);

    finish_run();
  end
endmodule